// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block sits next to a dispatch-group former and watches for a load that would read bytes written by a store placed earlier in the same group. Each memory access is described by a footprint: a base identifier, a signed byte offset from that base, and a byte size. The block keeps a small list of store footprints. Each accepted store strobe adds one entry, and the group-clear strobe empties the list. On every load query, the block compares the load footprint against all live entries in parallel.

The result is a single registered flag. The dispatch checker reads it one cycle after the query and turns it into a request to insert a no-op. Accesses that use different base identifiers are always treated as independent. No address translation is done, and only the base-plus-offset byte ranges are compared.

A load query is compared against the entries held before the clock edge at which it is sampled. A store strobe in the same cycle is therefore not visible to that load. A clear in the same cycle does not hide the old entries from that load.

Top module: `store_load_overlap`

## Requirements
- R1: The list accepts up to DEPTH (default 4) stores per group. Each store strobe while the list is not full and no clear is present adds one entry, and a later load in the same group is compared against every added entry.
- R2: A store strobe that arrives while DEPTH entries are already held is ignored, so a load matching only that store raises no hazard.
- R3: A load whose base and offset both equal those of a live entry is a hit, even when either size is zero.
- R4: With equal bases and the store offset strictly below the load offset, it is a hit exactly when store offset plus store size is greater than the load offset.
- R5: With equal bases and the store offset at or above the load offset, it is a hit exactly when load offset plus load size is greater than the store offset.
- R6: A load whose base identifier differs from that of every live entry never raises a hazard.
- R7: `hazard_o` is high in the cycle after a query edge only when the load valid was high at that edge and at least one live entry hit. With no load valid, or with an empty list, it is low.
- R8: The group-clear strobe discards all entries at the next edge. A store strobe in the same cycle as a clear is dropped.
- R9: Offsets are two's-complement signed values. The sum of offset and size is formed without overflow, so footprints near the most positive offset and at negative offsets compare correctly.
- R10: After a synchronous reset the list is empty and `hazard_o` is low.
- R11: A load is compared against the entries held before its sampling edge. A store strobed in the same cycle is seen only by later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid_i | input | 1 | Record the store footprint this cycle |
| st_base_i | input | BASE_W | Store base identifier |
| st_off_i | input | OFF_W | Store signed byte offset |
| st_size_i | input | SIZE_W | Store size in bytes |
| ld_valid_i | input | 1 | Load query valid |
| ld_base_i | input | BASE_W | Load base identifier |
| ld_off_i | input | OFF_W | Load signed byte offset |
| ld_size_i | input | SIZE_W | Load size in bytes |
| grp_clr_i | input | 1 | Dispatch group boundary: drop all entries |
| hazard_o | output | 1 | Registered overlap flag for the previous query |

## Verification
The hardest situation to reach from the ports is an overflow at the edge of the offset range. A sum such as offset plus size, taken near the most positive offset, wraps to a negative value unless the comparison is widened. The stimulus places stores at offset 32760 and at small negative offsets, then probes loads just inside and just outside each range. A second awkward state is a full list that meets a fifth store in the same group. The stimulus fills all four slots, sends the extra store, and queries its footprint before and after a clear that coincides with a new store strobe.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Default geometry of the detector.
  localparam int DEF_DEPTH  = 4;
  localparam int DEF_BASE_W = 8;
  localparam int DEF_OFF_W  = 16;
  localparam int DEF_SIZE_W = 5;
endpackage

// File: rtl/sld_store_list.sv
module sld_store_list #(
  parameter int DEPTH  = sld_pkg::DEF_DEPTH,
  parameter int BASE_W = sld_pkg::DEF_BASE_W,
  parameter int OFF_W  = sld_pkg::DEF_OFF_W,
  parameter int SIZE_W = sld_pkg::DEF_SIZE_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_i,
  input  logic                          clr_i,
  input  logic [BASE_W-1:0]             base_i,
  input  logic [OFF_W-1:0]              off_i,
  input  logic [SIZE_W-1:0]             size_i,
  output logic [DEPTH-1:0][BASE_W-1:0]  base_o,
  output logic [DEPTH-1:0][OFF_W-1:0]   off_o,
  output logic [DEPTH-1:0][SIZE_W-1:0]  size_o,
  output logic [DEPTH-1:0]              live_o,
  output logic                          empty_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0]                 cnt_q;
  logic [DEPTH-1:0][BASE_W-1:0]  base_q;
  logic [DEPTH-1:0][OFF_W-1:0]   off_q;
  logic [DEPTH-1:0][SIZE_W-1:0]  size_q;
  logic                          accept;

  assign accept = wr_i && !clr_i && (cnt_q < FULL);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // Entry payloads carry no reset; only the count qualifies them.
  always_ff @(posedge clk) begin
    if (accept) begin
      base_q[cnt_q[CW-1:0]] <= base_i;
      off_q[cnt_q[CW-1:0]]  <= off_i;
      size_q[cnt_q[CW-1:0]] <= size_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    assign live_o[i] = (cnt_q > CW'(i));
  end

  assign base_o  = base_q;
  assign off_o   = off_q;
  assign size_o  = size_q;
  assign empty_o = (cnt_q == '0);

  // R8
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> empty_o);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL && !clr_i) |=> (cnt_q == FULL));

  // R1
  store_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !clr_i && cnt_q < FULL) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R1
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !clr_i && cnt_q < FULL) |=> (off_o[$past(cnt_q)] == $past(off_i)));
endmodule

// File: rtl/sld_range_cmp.sv
module sld_range_cmp #(
  parameter int BASE_W = sld_pkg::DEF_BASE_W,
  parameter int OFF_W  = sld_pkg::DEF_OFF_W,
  parameter int SIZE_W = sld_pkg::DEF_SIZE_W
) (
  input  logic              live_i,
  input  logic [BASE_W-1:0] st_base_i,
  input  logic [OFF_W-1:0]  st_off_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              hit_o
);
  // Two guard bits: one for sign, one for the carry of offset + size.
  localparam int EW = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 2;

  logic signed [EW-1:0] s_lo, l_lo, s_hi, l_hi;
  logic                 same_base, exact, overlap;

  always_comb begin
    s_lo = EW'($signed(st_off_i));
    l_lo = EW'($signed(ld_off_i));
    s_hi = s_lo + $signed(EW'(st_size_i));
    l_hi = l_lo + $signed(EW'(ld_size_i));
    same_base = (st_base_i == ld_base_i);
    exact     = (s_lo == l_lo);
    if (s_lo < l_lo) overlap = (s_hi > l_lo);
    else             overlap = (l_hi > s_lo);
    hit_o = live_i && same_base && (exact || overlap);
  end
endmodule

// File: rtl/store_load_overlap.sv
module store_load_overlap #(
  parameter int DEPTH  = sld_pkg::DEF_DEPTH,
  parameter int BASE_W = sld_pkg::DEF_BASE_W,
  parameter int OFF_W  = sld_pkg::DEF_OFF_W,
  parameter int SIZE_W = sld_pkg::DEF_SIZE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid_i,
  input  logic [BASE_W-1:0] st_base_i,
  input  logic [OFF_W-1:0]  st_off_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              ld_valid_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  input  logic              grp_clr_i,
  output logic              hazard_o
);
  logic [DEPTH-1:0][BASE_W-1:0] e_base;
  logic [DEPTH-1:0][OFF_W-1:0]  e_off;
  logic [DEPTH-1:0][SIZE_W-1:0] e_size;
  logic [DEPTH-1:0]             e_live;
  logic [DEPTH-1:0]             hit_vec;
  logic                         list_empty;
  logic                         hazard_q;

  sld_store_list #(
    .DEPTH(DEPTH), .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_list (
    .clk(clk), .rst(rst),
    .wr_i(st_valid_i), .clr_i(grp_clr_i),
    .base_i(st_base_i), .off_i(st_off_i), .size_i(st_size_i),
    .base_o(e_base), .off_o(e_off), .size_o(e_size),
    .live_o(e_live), .empty_o(list_empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    sld_range_cmp #(
      .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
    ) u_cmp (
      .live_i(e_live[i]),
      .st_base_i(e_base[i]), .st_off_i(e_off[i]), .st_size_i(e_size[i]),
      .ld_base_i(ld_base_i), .ld_off_i(ld_off_i), .ld_size_i(ld_size_i),
      .hit_o(hit_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) hazard_q <= 1'b0;
    else     hazard_q <= ld_valid_i && (|hit_vec);
  end

  assign hazard_o = hazard_q;

  // R7
  no_load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid_i |=> !hazard_o);

  // R7
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid_i && list_empty) |=> !hazard_o);

  // R10
  always_ff @(posedge clk) begin
    if ($past(rst)) reset_low_chk: assert (!hazard_o);
  end
endmodule

// File: tb/tb_store_load_overlap.sv
module tb_store_load_overlap;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid_i = 1'b0, ld_valid_i = 1'b0, grp_clr_i = 1'b0;
  logic [7:0]  st_base_i = '0, ld_base_i = '0;
  logic [15:0] st_off_i = '0, ld_off_i = '0;
  logic [4:0]  st_size_i = '0, ld_size_i = '0;
  logic        hazard_o;

  always #4 clk = ~clk;  // 125 MHz

  store_load_overlap dut (
    .clk(clk), .rst(rst),
    .st_valid_i(st_valid_i), .st_base_i(st_base_i), .st_off_i(st_off_i), .st_size_i(st_size_i),
    .ld_valid_i(ld_valid_i), .ld_base_i(ld_base_i), .ld_off_i(ld_off_i), .ld_size_i(ld_size_i),
    .grp_clr_i(grp_clr_i), .hazard_o(hazard_o)
  );

  typedef struct { bit exp; string tag; } item_t;
  item_t q[$];

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // Reference list, built from the requirements
  int m_base[DEPTH], m_off[DEPTH], m_sz[DEPTH];
  int m_cnt = 0;

  function automatic bit model_hit(int lb, int lo, int ls);
    for (int i = 0; i < m_cnt; i++) begin
      if (m_base[i] == lb) begin
        if (m_off[i] == lo) return 1;
        if (m_off[i] < lo) begin
          if (m_off[i] + m_sz[i] > lo) return 1;
        end else if (lo + ls > m_off[i]) return 1;
      end
    end
    return 0;
  endfunction

  // Driver: one cycle of stimulus plus its expected result
  task automatic cyc(bit sv, int sb, int so, int ss,
                     bit lv, int lb, int lo, int ls, bit clr, string tag);
    item_t it;
    @(negedge clk);
    st_valid_i = sv; st_base_i = 8'(sb); st_off_i = 16'(so); st_size_i = 5'(ss);
    ld_valid_i = lv; ld_base_i = 8'(lb); ld_off_i = 16'(lo); ld_size_i = 5'(ls);
    grp_clr_i = clr;
    it.exp = lv && model_hit(lb, lo, ls);
    it.tag = tag;
    q.push_back(it);
    if (clr) m_cnt = 0;
    else if (sv && m_cnt < DEPTH) begin
      m_base[m_cnt] = sb; m_off[m_cnt] = so; m_sz[m_cnt] = ss; m_cnt++;
    end
  endtask

  task automatic st(int b, int o, int s, string tag);
    cyc(1, b, o, s, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ld(int b, int o, int s, string tag);
    cyc(0, 0, 0, 0, 1, b, o, s, 0, tag);
  endtask
  task automatic clr(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  // Monitor: compare each result after the edge that registers it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (hazard_o !== it.exp) begin
        fails++;
        $display("FAIL %s: hazard_o=%b expected %b", it.tag, hazard_o, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: empty after reset, no hazard
    ld(1, 8, 4, "R10");
    // R3: exact match even with zero size
    st(1, 8, 0, "R1");
    ld(1, 8, 0, "R3");
    // R7: no load valid -> no hazard
    cyc(0, 0, 0, 0, 0, 1, 8, 4, 0, "R7");
    // R6: different base
    ld(2, 8, 4, "R6");
    clr("R8");
    // R4: store below load
    st(3, 0, 4, "R1");
    ld(3, 3, 1, "R4");
    ld(3, 4, 4, "R4");
    clr("R8");
    // R5: store at or above load
    st(4, 10, 2, "R1");
    ld(4, 6, 4, "R5");
    ld(4, 6, 5, "R5");
    clr("R8");
    // R1, R2: four entries then an ignored fifth
    for (int i = 0; i < 4; i++) st(5, i * 16, 4, "R1");
    st(5, 64, 4, "R2");
    ld(5, 0, 2, "R1");
    ld(5, 48, 4, "R1");
    ld(5, 64, 4, "R2");
    // R8: clear with a store in the same cycle; the load in that cycle sees old entries
    cyc(1, 5, 96, 4, 1, 5, 16, 4, 1, "R8");
    ld(5, 96, 4, "R8");
    ld(5, 16, 4, "R8");
    // R11: store and load in the same cycle
    cyc(1, 6, 20, 4, 1, 6, 20, 4, 0, "R11");
    ld(6, 20, 4, "R11");
    clr("R8");
    // R9: edge of the positive range and negative offsets
    st(7, 32760, 16, "R9");
    ld(7, 32767, 1, "R9");
    st(8, -5, 4, "R9");
    ld(8, -1, 1, "R9");
    clr("R8");
    st(8, -5, 5, "R9");
    ld(8, -1, 1, "R9");
    ld(8, -9, 4, "R9");
    ld(8, -9, 5, "R9");
    // R7: load with empty list after clear
    clr("R8");
    ld(8, -5, 5, "R7");
    @(negedge clk);
    ld_valid_i = 0; st_valid_i = 0; grp_clr_i = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule